// File: doc/BRIEF.md
# Ring Token Adder Node

This block is one stage of a closed, synchronously clocked token ring. Each clock it registers the incoming slot (a valid flag, an address, a data word and a small side-band field) and hands it to the next stage, so every token moves one stage per cycle. Attached to the stage is a two-operand adder that takes its work from the ring and puts its answer back onto it.

Many identical nodes share one request address. While idle, a node watches for a valid token carrying that address. The first idle node to see such a token claims it: it removes the token from the ring by clearing the slot's valid flag, then re-tags itself with an operation tag taken from the token. From then on it answers only to that tag. It gathers an A and a B operand in either order, and computes their sum over a fixed number of cycles. It then waits for an empty slot in which to place the sum, addressed to the destination named in the claiming token. After sending, the node answers to the shared request address again. No central scheduler is needed, because claiming is decided by position on the ring.

Top module: `ring_add_node`

## Requirements
- R1: A token that the node does not capture or replace appears on the downstream side exactly one cycle later, with valid, address, data and side-band unchanged.
- R2: After reset the downstream valid is 0 and the node is idle, answering to the request address `OPCODE` (default 4'hA).
- R3: In the idle state, a token with valid 1 and address equal to `OPCODE` is captured: one cycle later the downstream valid is 0, while address, data and side-band are forwarded unchanged.
- R4: The claiming token's data carries the operation tag in its top `ADDR_W` bits (bits 15:12 by default) and the result address in its low `ADDR_W` bits (bits 3:0). After the claim, tokens addressed to `OPCODE` pass through untouched.
- R5: While gathering, a valid token whose address equals the tag is captured as an operand. Side-band bit 0 selects the operand (0 = A, 1 = B), and A and B may arrive in either order.
- R6: A second operand token for an input that is already filled overwrites it. The later value is the one summed.
- R7: A token with valid 0 is never captured, whatever its address. It passes through as in R1.
- R8: Once both operands are held, the node stays busy for `LATENCY` cycles (default 3). During this time every token passes through as in R1, including tokens that match the tag or `OPCODE`.
- R9: After the busy time the node replaces the first slot whose incoming valid is 0. That slot goes out with valid 1, the stored result address, data equal to (A + B) mod 2^DATA_W, and side-band 0.
- R10: While `stall` is 1 the node inserts nothing. The waiting result is kept until a cycle in which the slot is empty and `stall` is 0.
- R11: After inserting its result the node is idle again and captures the next valid token addressed to `OPCODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_valid | input | 1 | Incoming slot holds a token |
| up_addr | input | ADDR_W | Incoming token address |
| up_data | input | DATA_W | Incoming token data |
| up_info | input | INFO_W | Incoming side-band; bit 0 selects operand A/B |
| stall | input | 1 | Ring-wide hold-off for insertion |
| dn_valid | output | 1 | Outgoing slot holds a token |
| dn_addr | output | ADDR_W | Outgoing token address |
| dn_data | output | DATA_W | Outgoing token data |
| dn_info | output | INFO_W | Outgoing side-band |

## Verification
The hardest situation to reach from the ports is a finished result that meets a run of full slots and then a stall asserted over an empty slot. Only then can a node that inserts too early, or drops its result, be seen. The stimulus reaches it by keeping the ring full of traffic across the busy window. It then holds the stall high over an empty slot before it finally offers a free one. A behavioural model in the bench predicts every slot, so any early insertion, missed capture or wrong sum shows up in the cycle where it happens. The operand paths are driven in both orders, with overwrites, and with a sum that wraps past the word width.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_BUSY   = 2'd2,
    ST_SEND   = 2'd3
  } node_state_e;
endpackage

// File: rtl/node_match.sv
module node_match #(
  parameter int ADDR_W = 4
) (
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit
);
  always_comb begin
    hit = tok_valid && (tok_addr == cmp_addr);
  end
endmodule

// File: rtl/node_operands.sv
module node_operands #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_a,
  input  logic              load_b,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              have_a,
  output logic              have_b
);
  logic have_a_d, have_b_d;
  logic [DATA_W-1:0] opa_d, opb_d;

  always_comb begin
    have_a_d = have_a;
    have_b_d = have_b;
    opa_d    = opa;
    opb_d    = opb;
    if (clr) begin
      have_a_d = 1'b0;
      have_b_d = 1'b0;
    end else begin
      if (load_a) begin
        have_a_d = 1'b1;
        opa_d    = din;
      end
      if (load_b) begin
        have_b_d = 1'b1;
        opb_d    = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a <= 1'b0;
      have_b <= 1'b0;
      opa    <= '0;
      opb    <= '0;
    end else begin
      have_a <= have_a_d;
      have_b <= have_b_d;
      opa    <= opa_d;
      opb    <= opb_d;
    end
  end
endmodule

// File: rtl/node_ctrl.sv
module node_ctrl
  import ring_node_pkg::*;
#(
  parameter int              ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] OPCODE = 4'hA,
  parameter int              LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              hit,
  input  logic              sel_b,
  input  logic [ADDR_W-1:0] setup_tag,
  input  logic [ADDR_W-1:0] setup_res,
  input  logic              have_a,
  input  logic              have_b,
  input  logic              stall,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [ADDR_W-1:0] res_addr,
  output logic              capture,
  output logic              clr_opnd,
  output logic              load_a,
  output logic              load_b,
  output logic              insert,
  output node_state_e       state
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  node_state_e       state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] tag_q, tag_d, res_d;
  logic              setup, opnd, both;

  always_comb begin
    cmp_addr = (state == ST_IDLE) ? OPCODE : tag_q;
    setup    = hit && (state == ST_IDLE);
    opnd     = hit && (state == ST_GATHER);
    capture  = setup || opnd;
    clr_opnd = setup;
    load_a   = opnd && !sel_b;
    load_b   = opnd && sel_b;
    both     = (have_a || load_a) && (have_b || load_b);
    insert   = (state == ST_SEND) && !up_valid && !stall;

    state_d = state;
    cnt_d   = cnt_q;
    tag_d   = tag_q;
    res_d   = res_addr;
    case (state)
      ST_IDLE: begin
        if (setup) begin
          state_d = ST_GATHER;
          tag_d   = setup_tag;
          res_d   = setup_res;
        end
      end
      ST_GATHER: begin
        if (opnd && both) begin
          state_d = ST_BUSY;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_BUSY: begin
        if (cnt_q == '0) state_d = ST_SEND;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_SEND: begin
        if (insert) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      tag_q    <= '0;
      res_addr <= '0;
    end else begin
      state    <= state_d;
      cnt_q    <= cnt_d;
      tag_q    <= tag_d;
      res_addr <= res_d;
    end
  end
endmodule

// File: rtl/node_slot.sv
module node_slot #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int INFO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  input  logic [INFO_W-1:0] up_info,
  input  logic              capture,
  input  logic              insert,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  output logic              dn_valid,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [INFO_W-1:0] dn_info
);
  logic              v_d;
  logic [ADDR_W-1:0] a_d;
  logic [DATA_W-1:0] d_d;
  logic [INFO_W-1:0] i_d;

  always_comb begin
    v_d = up_valid;
    a_d = up_addr;
    d_d = up_data;
    i_d = up_info;
    if (insert) begin
      v_d = 1'b1;
      a_d = ins_addr;
      d_d = ins_data;
      i_d = '0;
    end else if (capture) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_addr  <= '0;
      dn_data  <= '0;
      dn_info  <= '0;
    end else begin
      dn_valid <= v_d;
      dn_addr  <= a_d;
      dn_data  <= d_d;
      dn_info  <= i_d;
    end
  end
endmodule

// File: rtl/ring_add_node.sv
module ring_add_node
  import ring_node_pkg::*;
#(
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 4,
  parameter int                INFO_W  = 2,
  parameter logic [ADDR_W-1:0] OPCODE  = 4'hA,
  parameter int                LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  input  logic [INFO_W-1:0] up_info,
  input  logic              stall,
  output logic              dn_valid,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [INFO_W-1:0] dn_info
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [ADDR_W-1:0] cmp_addr, res_addr;
  logic              hit, capture, clr_opnd, load_a, load_b, insert;
  logic              have_a, have_b;
  logic [DATA_W-1:0] opa, opb, sum;
  node_state_e       st;

  node_match #(.ADDR_W(ADDR_W)) u_match (
    .tok_valid (up_valid),
    .tok_addr  (up_addr),
    .cmp_addr  (cmp_addr),
    .hit       (hit)
  );

  node_ctrl #(.ADDR_W(ADDR_W), .OPCODE(OPCODE), .LATENCY(LATENCY)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .up_valid  (up_valid),
    .hit       (hit),
    .sel_b     (up_info[0]),
    .setup_tag (up_data[DATA_W-1 -: ADDR_W]),
    .setup_res (up_data[ADDR_W-1:0]),
    .have_a    (have_a),
    .have_b    (have_b),
    .stall     (stall),
    .cmp_addr  (cmp_addr),
    .res_addr  (res_addr),
    .capture   (capture),
    .clr_opnd  (clr_opnd),
    .load_a    (load_a),
    .load_b    (load_b),
    .insert    (insert),
    .state     (st)
  );

  node_operands #(.DATA_W(DATA_W)) u_opnd (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (clr_opnd),
    .load_a (load_a),
    .load_b (load_b),
    .din    (up_data),
    .opa    (opa),
    .opb    (opb),
    .have_a (have_a),
    .have_b (have_b)
  );

  always_comb begin
    sum = opa + opb;
  end

  node_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INFO_W(INFO_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_s),
    .up_valid (up_valid),
    .up_addr  (up_addr),
    .up_data  (up_data),
    .up_info  (up_info),
    .capture  (capture),
    .insert   (insert),
    .ins_addr (res_addr),
    .ins_data (sum),
    .dn_valid (dn_valid),
    .dn_addr  (dn_addr),
    .dn_data  (dn_data),
    .dn_info  (dn_info)
  );
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk
  import ring_node_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                ADDR_W = 4,
  parameter int                INFO_W = 2,
  parameter logic [ADDR_W-1:0] OPCODE = 4'hA
) (
  input logic              clk,
  input logic              rst_s,
  input node_state_e       st,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_addr,
  input logic [DATA_W-1:0] up_data,
  input logic              stall,
  input logic              dn_valid,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_data,
  input logic [INFO_W-1:0] dn_info
);
  // R3: an idle node that sees its request address frees the slot
  p_idle_claim_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_IDLE && up_valid && up_addr == OPCODE) |=> !dn_valid);

  // R1: idle traffic for another address is forwarded unchanged
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_IDLE && up_addr != OPCODE) |=>
      (dn_valid == $past(up_valid) && dn_addr == $past(up_addr) && dn_data == $past(up_data)));

  // R8: a busy node forwards everything
  p_busy_pass_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_BUSY) |=> (dn_valid == $past(up_valid) && dn_data == $past(up_data)));

  // R10: no insertion under stall
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_SEND && stall) |=> (dn_valid == $past(up_valid) && st == ST_SEND));

  // R9: an inserted result carries side-band 0 and never overwrites a full slot
  p_insert_empty_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_SEND && !up_valid && !stall) |=> (dn_valid && dn_info == '0 && st == ST_IDLE));

  // R7: an empty slot never leaves the idle state
  p_empty_ignored_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_IDLE && !up_valid) |=> st == ST_IDLE);
endmodule

bind ring_add_node ring_node_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INFO_W(INFO_W), .OPCODE(OPCODE)
) i_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .st       (st),
  .up_valid (up_valid),
  .up_addr  (up_addr),
  .up_data  (up_data),
  .stall    (stall),
  .dn_valid (dn_valid),
  .dn_addr  (dn_addr),
  .dn_data  (dn_data),
  .dn_info  (dn_info)
);

// File: tb/test_ring_add_node.sv
module test_ring_add_node;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam logic [AW-1:0] OPC = 4'hA;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic up_valid, stall;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_data;
  logic [IW-1:0] up_info;
  logic dn_valid;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_data;
  logic [IW-1:0] dn_info;

  always #2 clk = ~clk;

  ring_add_node #(.DATA_W(DW), .ADDR_W(AW), .INFO_W(IW), .OPCODE(OPC), .LATENCY(LAT)) i_ring_add_node (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_addr(up_addr), .up_data(up_data),
    .up_info(up_info), .stall(stall), .dn_valid(dn_valid), .dn_addr(dn_addr),
    .dn_data(dn_data), .dn_info(dn_info)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference: mode 0 idle, 1 gathering, 2 computing, 3 waiting to send
  int mode = 0;
  int tag = 0, dest = 0, wait_left = 0;
  int va = 0, vb = 0;
  bit got_a = 0, got_b = 0;
  logic e_v;
  logic [AW-1:0] e_a;
  logic [DW-1:0] e_d;
  logic [IW-1:0] e_i;

  task automatic model_edge();
    e_v = up_valid; e_a = up_addr; e_d = up_data; e_i = up_info;
    if (mode == 0) begin
      if (up_valid && up_addr == OPC) begin
        e_v = 1'b0; mode = 1;
        tag = int'(up_data[DW-1:DW-AW]); dest = int'(up_data[AW-1:0]);
        got_a = 0; got_b = 0;
      end
    end else if (mode == 1) begin
      if (up_valid && int'(up_addr) == tag) begin
        e_v = 1'b0;
        if (up_info[0]) begin vb = int'(up_data); got_b = 1; end
        else            begin va = int'(up_data); got_a = 1; end
        if (got_a && got_b) begin mode = 2; wait_left = LAT; end
      end
    end else if (mode == 2) begin
      wait_left--;
      if (wait_left == 0) mode = 3;
    end else begin
      if (!up_valid && !stall) begin
        e_v = 1'b1; e_a = AW'(dest); e_d = DW'(va + vb); e_i = '0; mode = 0;
      end
    end
  endtask

  task automatic check(string req);
    total++;
    if (dn_valid !== e_v || dn_addr !== e_a || dn_data !== e_d || dn_info !== e_i) begin
      bad++;
      $display("FAIL %s: got v=%0b a=%h d=%h i=%h expected v=%0b a=%h d=%h i=%h",
               req, dn_valid, dn_addr, dn_data, dn_info, e_v, e_a, e_d, e_i);
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [IW-1:0] i, input logic w, input string req);
    up_valid = v; up_addr = a; up_data = d; up_info = i; stall = w;
    @(posedge clk);
    cycles++;
    model_edge();
    #1;
    check(req);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_valid = 0; up_addr = '0; up_data = '0; up_info = '0; stall = 0;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    e_v = 0; e_a = '0; e_d = '0; e_i = '0;
    check("R2");
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(0, 4'h0, 16'h0, 2'b0, 0, "R2");

    // R1: passing traffic, several patterns
    step(1, 4'h3, 16'hBEEF, 2'b10, 0, "R1");
    step(1, 4'h5, 16'h1234, 2'b01, 0, "R1");
    step(0, 4'hA, 16'h5555, 2'b11, 0, "R7");   // empty slot with request address
    step(1, 4'hB, 16'hAAAA, 2'b00, 0, "R1");

    // R3/R4: claim with tag 5, result address 9
    step(1, OPC, 16'h5009, 2'b00, 0, "R3");
    step(1, OPC, 16'h7001, 2'b00, 0, "R4");   // must pass now
    step(0, 4'h5, 16'h0099, 2'b00, 0, "R7");  // empty slot with tag
    step(1, 4'h6, 16'h0042, 2'b00, 0, "R1");
    // R5/R6: A, overwrite A, then B
    step(1, 4'h5, 16'h0100, 2'b00, 0, "R5");
    step(1, 4'h5, 16'h1234, 2'b00, 0, "R6");
    step(1, 4'h5, 16'h0F00, 2'b01, 0, "R5");
    // R8: busy, matching tokens pass
    step(1, 4'h5, 16'h0001, 2'b00, 0, "R8");
    step(1, OPC, 16'h3003, 2'b00, 0, "R8");
    step(0, 4'h0, 16'h0000, 2'b00, 0, "R8");
    // R9/R10: full slots, then stall over empty slots, then free slot
    step(1, 4'h1, 16'h1111, 2'b00, 0, "R9");
    step(1, 4'h2, 16'h2222, 2'b00, 0, "R9");
    step(0, 4'h0, 16'h0000, 2'b00, 1, "R10");
    step(0, 4'h0, 16'h0000, 2'b00, 1, "R10");
    step(0, 4'h0, 16'h7777, 2'b11, 0, "R9");  // expect 0x2134 to address 9
    step(0, 4'h0, 16'h0000, 2'b00, 0, "R9");

    // R11: idle again, second operation, B first, wrapping sum
    step(1, OPC, 16'hC00E, 2'b00, 0, "R11");
    step(1, 4'hC, 16'h0002, 2'b01, 0, "R5");
    step(1, 4'h3, 16'h0BAD, 2'b00, 0, "R1");
    step(1, 4'hC, 16'hFFFF, 2'b10, 0, "R5");
    for (int k = 0; k < LAT; k++) step(1, 4'hC, 16'h00F0, 2'b00, 0, "R8");
    step(0, 4'h0, 16'h0000, 2'b00, 0, "R9");  // expect 0x0001 to address E
    step(1, OPC, 16'h1002, 2'b00, 0, "R11");
    step(1, 4'h1, 16'h0005, 2'b00, 0, "R5");
    step(1, 4'h1, 16'h0006, 2'b01, 0, "R5");
    for (int k = 0; k < LAT; k++) step(0, 4'h0, 16'h0000, 2'b00, 0, "R8");
    step(0, 4'h0, 16'h0000, 2'b00, 0, "R9");  // expect 0x000B to address 2
    step(0, 4'h0, 16'h0000, 2'b00, 0, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule